// File: doc/BRIEF.md
# Prescaled Timebase with Event Capture

This block produces a wide timebase from two counters clocked by the timer clock. A prescale counter counts up from zero and is compared with a programmable limit. When the counter reaches the limit it returns to zero, and a free-running counter advances by one. The limit therefore sets the ratio between the timer clock and the rate of the free-running count.

A capture register takes a snapshot of the free-running counter when a one-cycle event pulse arrives, so software can timestamp external events. A counter-enable input freezes both counters while it is low.

A small register port reads the limit, the snapshot and both live counters. It also writes the limit. A write takes effect only when the access is privileged and the block is not switched to an external timebase. A write that is refused is dropped without any signal. The counter width is the parameter `CNT_W`, which defaults to 32.

Top module: `tbc_top`

## Requirements
- R1: After reset, the limit, the prescale counter, the free-running counter and the snapshot all read 0.
- R2: With a nonzero limit N and the enable high, the prescale counter goes through 0..N. On each clock edge where it equals N, it returns to 0 and the free-running counter adds one, so the free-running counter advances once every N+1 enabled clocks.
- R3: With a limit of 0, the prescale counter counts through its whole range and wraps from all-ones to 0. It then stays at 0 for one more enabled clock, and on that clock the free-running counter adds one. The period is 2^CNT_W+1 enabled clocks.
- R4: A write to the limit while `ext_tb_sel` is 1 leaves the limit unchanged.
- R5: A write to the limit while `bus_priv` is 0 leaves the limit unchanged.
- R6: A privileged write to the limit while `ext_tb_sel` is 0 stores `bus_wdata`, and a later read of the limit returns that value.
- R7: Reads return the following by `bus_addr`: 08h the prescale counter, 0Ch the free-running counter, 18h the limit, 20h the snapshot, and 0 at any other offset.
- R8: A high `cap_evt` on a clock edge loads the snapshot with the free-running count. While `cap_evt` is low, the snapshot holds its value.
- R9: If `cap_evt` is high on the same edge where the free-running counter adds one, the snapshot gets the count from before the increment.
- R10: While `cnt_en` is 0, neither counter changes.
- R11: Writes to any offset other than 18h change nothing. This includes the snapshot at 20h, which is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_en | input | 1 | Counter enable; when 0, both counters hold |
| cap_evt | input | 1 | One-cycle capture event pulse |
| ext_tb_sel | input | 1 | External timebase selected; blocks limit writes |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |

## Verification
The case that is hardest to reach is the zero-limit wrap. It needs the prescale counter to pass all-ones, and at 32 bits that takes more than four billion clocks. The bench therefore builds the block with a narrow `CNT_W`, because the wrap and hold logic does not depend on the width. It then runs one period plus one clock, and a second full period. This shows the extra clock spent at 0 and the 2^CNT_W+1 period. A capture that lands exactly on an increment edge is also set up on purpose: the bench counts enabled clocks up to the edge where the prescale counter equals the limit, and raises the capture pulse on that edge.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_PRE = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_FRC = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CMP = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CAP = 8'h20;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_PRE,
    RSEL_FRC,
    RSEL_CMP,
    RSEL_CAP
  } rsel_e;

  function automatic rsel_e decode_rsel(input logic [ADDR_W-1:0] addr);
    case (addr)
      OFS_PRE: return RSEL_PRE;
      OFS_FRC: return RSEL_FRC;
      OFS_CMP: return RSEL_CMP;
      OFS_CAP: return RSEL_CAP;
      default: return RSEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tbc_rst_sync.sv
module tbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tbc_prescaler.sv
module tbc_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic         tick_o
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap_q, wrap_d;
  logic         hit;

  // A zero limit only matches on the extra clock that follows a wrap
  always_comb begin
    hit    = (cnt_q == cmp_i) && ((cmp_i != '0) || wrap_q);
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    if (en_i) begin
      if (hit) begin
        cnt_d  = '0;
        wrap_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == ALL_ONES) wrap_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = en_i && hit;

  assert_clear_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_wrap_then_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cmp_i == '0 && cnt_q == ALL_ONES) |=> (cnt_q == '0 && wrap_q));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/tbc_freerun.sv
module tbc_freerun #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         cap_i,
  output logic [W-1:0] frc_o,
  output logic [W-1:0] cap_o
);
  logic [W-1:0] frc_q, frc_d;
  logic [W-1:0] cap_q, cap_d;

  always_comb begin
    frc_d = tick_i ? frc_q + 1'b1 : frc_q;
    cap_d = cap_i ? frc_q : cap_q;   // count before any increment on this edge
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_q <= '0;
      cap_q <= '0;
    end else begin
      frc_q <= frc_d;
      cap_q <= cap_d;
    end
  end

  assign frc_o = frc_q;
  assign cap_o = cap_q;

  assert_frc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (frc_q == $past(frc_q) + 1'b1));
  assert_frc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(frc_q));
  assert_cap_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (cap_q == $past(frc_q)));
  assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(cap_q));
endmodule

// File: rtl/tbc_regif.sv
module tbc_regif
  import tbc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              priv_i,
  input  logic              ext_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pre_i,
  input  logic [W-1:0]      frc_i,
  input  logic [W-1:0]      cap_i,
  output logic [W-1:0]      cmp_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] cmp_q, cmp_d;
  logic         cmp_we;
  rsel_e        rsel;

  always_comb begin
    rsel   = decode_rsel(addr_i);
    cmp_we = wr_i && priv_i && !ext_i && (rsel == RSEL_CMP);
    cmp_d  = cmp_we ? wdata_i : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_d;
  end

  always_comb begin
    case (rsel)
      RSEL_PRE: rdata_o = pre_i;
      RSEL_FRC: rdata_o = frc_i;
      RSEL_CMP: rdata_o = cmp_q;
      RSEL_CAP: rdata_o = cap_i;
      default:  rdata_o = '0;
    endcase
  end

  assign cmp_o = cmp_q;

  assert_ext_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ext_i) |=> $stable(cmp_q));
  assert_unpriv_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !priv_i) |=> $stable(cmp_q));
  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && priv_i && !ext_i && addr_i == OFS_CMP) |=> (cmp_q == $past(wdata_i)));
  assert_other_ofs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i != OFS_CMP) |=> $stable(cmp_q));
endmodule

// File: rtl/tbc_top.sv
module tbc_top
  import tbc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              cap_evt,
  input  logic              ext_tb_sel,
  input  logic              bus_wr,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] cmp, pre, frc, cap;
  logic             tick;

  tbc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_sync_n)
  );

  tbc_prescaler #(.W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .en_i(cnt_en), .cmp_i(cmp),
    .cnt_o(pre), .tick_o(tick)
  );

  tbc_freerun #(.W(CNT_W)) u_frc (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(tick), .cap_i(cap_evt),
    .frc_o(frc), .cap_o(cap)
  );

  tbc_regif #(.W(CNT_W)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .wr_i(bus_wr), .priv_i(bus_priv),
    .ext_i(ext_tb_sel), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .pre_i(pre), .frc_i(frc), .cap_i(cap), .cmp_o(cmp), .rdata_o(bus_rdata)
  );

  assert_tick_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cnt_en |=> $stable(frc));
endmodule

// File: tb/test_tbc_top.sv
module test_tbc_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 10;
  localparam logic [7:0] A_PRE = 8'h08, A_FRC = 8'h0C, A_CMP = 8'h18, A_CAP = 8'h20;

  typedef struct packed {
    int lim;
    int cyc;
    int frc;
    int pre;
  } vec_t;

  // limit, enabled clocks, expected free-running count, expected prescale count
  localparam vec_t VECS [5] = '{
    '{3, 10, 2, 2}, '{1, 7, 3, 1}, '{5, 6, 1, 0}, '{9, 9, 0, 9}, '{2, 30, 10, 0}
  };

  logic clk = 1'b0;
  logic rst_n, cnt_en, cap_evt, ext_tb_sel, bus_wr, bus_priv;
  logic [7:0]   bus_addr;
  logic [W-1:0] bus_wdata, bus_rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbc_top #(.CNT_W(W)) i_tbc_top (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_evt(cap_evt),
    .ext_tb_sel(ext_tb_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d, input logic priv, input logic ext);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_priv = priv; ext_tb_sel = ext; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ext_tb_sel = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    rst_n = 1'b0; cnt_en = 1'b0; cap_evt = 1'b0; ext_tb_sel = 1'b0;
    bus_wr = 1'b0; bus_priv = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();

    // R1: reset values at all four offsets
    rd(A_CMP, d); check("R1", "limit", d, 0);
    rd(A_PRE, d); check("R1", "prescale", d, 0);
    rd(A_FRC, d); check("R1", "freerun", d, 0);
    rd(A_CAP, d); check("R1", "snapshot", d, 0);

    // R2 / R6 / R7: table of limits and run lengths
    for (int i = 0; i < 5; i++) begin
      do_reset();
      wr(A_CMP, W'(VECS[i].lim), 1'b1, 1'b0);
      rd(A_CMP, d); check("R6", "limit readback", d, W'(VECS[i].lim));
      run(VECS[i].cyc);
      rd(A_FRC, d); check("R2", "freerun", d, W'(VECS[i].frc));
      rd(A_PRE, d); check("R2", "prescale", d, W'(VECS[i].pre));
    end

    // R10: enable low holds both counters (limit 2, 30 clocks ran: frc 10, pre 0)
    repeat (7) @(negedge clk);
    rd(A_FRC, d); check("R10", "freerun hold", d, 10);
    rd(A_PRE, d); check("R10", "prescale hold", d, 0);

    // R4 / R5 / R11: blocked and misdirected writes
    wr(A_CMP, 7, 1'b1, 1'b1);
    rd(A_CMP, d); check("R4", "ext select blocks write", d, 2);
    wr(A_CMP, 9, 1'b0, 1'b0);
    rd(A_CMP, d); check("R5", "unprivileged write", d, 2);
    wr(A_CAP, 5, 1'b1, 1'b0);
    rd(A_CAP, d); check("R11", "snapshot read-only", d, 0);
    rd(A_CMP, d); check("R11", "limit after other write", d, 2);
    wr(A_FRC, 3, 1'b1, 1'b0);
    rd(A_FRC, d); check("R11", "freerun not writable", d, 10);
    rd(8'h04, d); check("R7", "unmapped offset", d, 0);

    // R8 / R9: snapshot with limit 3
    do_reset();
    wr(A_CMP, 3, 1'b1, 1'b0);
    run(5);
    @(negedge clk); cap_evt = 1'b1;
    @(negedge clk); cap_evt = 1'b0;
    rd(A_CAP, d); check("R8", "snapshot load", d, 1);
    run(6);                    // 11 clocks: frc 2, pre 3
    rd(A_CAP, d); check("R8", "snapshot holds", d, 1);
    rd(A_PRE, d); check("R2", "prescale at limit", d, 3);
    @(negedge clk); cnt_en = 1'b1; cap_evt = 1'b1;
    @(negedge clk); cnt_en = 1'b0; cap_evt = 1'b0;
    rd(A_CAP, d); check("R9", "snapshot pre-increment", d, 2);
    rd(A_FRC, d); check("R9", "freerun after edge", d, 3);

    // R3: zero limit, width W: wrap then one extra clock at zero
    do_reset();
    run(1 << W);
    rd(A_PRE, d); check("R3", "prescale wrapped", d, 0);
    rd(A_FRC, d); check("R3", "no advance at wrap", d, 0);
    run(1);
    rd(A_PRE, d); check("R3", "prescale held at zero", d, 0);
    rd(A_FRC, d); check("R3", "advance after hold", d, 1);
    run(1);
    rd(A_PRE, d); check("R3", "prescale resumes", d, 1);
    run((1 << W));
    rd(A_FRC, d); check("R3", "second period", d, 2);
    rd(A_PRE, d); check("R3", "second period prescale", d, 0);

    report();
    $finish;
  end
endmodule